// File: doc/BRIEF.md
# CAN Receive Message FIFO

This block holds received CAN frames for the host in a 64-byte circular RAM. The protocol core streams each frame into it one byte per cycle. The first byte of a frame is a descriptor, and the frame's length in bytes follows from that descriptor. When the last byte of a received frame is stored, the frame is committed and the message count goes up. The host reads the frame at the head through a 16-byte window that is relative to the current start address. A release command frees that frame, which moves the start address forward by the frame's length, wrapping around the RAM.

The frame that the controller itself is transmitting goes through the same write path. It is written at the current write position but is never committed, so it raises no status and no interrupt. It stays readable until a later frame overwrites it. When reset mode is entered, either by the host or because of bus-off, the pending frames are flushed. The write position is rewound to the current start address, not to address 0, and the RAM contents are left in place. A hardware reset puts both pointers at address 0.

Top module: `canrx_fifo`

## Requirements
- R1: After hardware reset, startAddr is 0, msgCount is 0, and rbFull, rxIrq and overrun are all 0.
- R2: Frame length in bytes comes from the descriptor (the first byte of the frame). It is 3 plus the data-length field, or 5 plus that field when descriptor bit 7 (extended identifier) is set. The data-length field is descriptor bits 3:0, and any value above 8 counts as 8. A received frame raises msgCount by one in the cycle after its last byte is accepted.
- R3: rbFull and rxIrq are both 1 exactly when msgCount is nonzero.
- R4: rbData returns the RAM byte at address (startAddr + rbAddr) mod 64. Offset 0 is the descriptor of the head frame.
- R5: A release with msgCount nonzero advances startAddr by the head frame's length, modulo 64, and lowers msgCount by one. A release with msgCount 0 has no effect.
- R6: A received frame whose length exceeds the free space sets overrun, and none of its bytes are stored. Free space is 64 minus the bytes held by committed frames. Overrun stays set until clrOvr is asserted or reset mode is entered.
- R7: A transmitted frame (wrTx high with its first byte) is written from the write position on but leaves msgCount, rbFull and rxIrq unchanged. It stays readable through the window while the FIFO is empty. A transmitted frame that does not fit in the free space is dropped without setting overrun.
- R8: While resetMode is high, msgCount and overrun are 0, startAddr keeps its current value, the write position returns to startAddr, and frame bytes and releases are ignored. RAM contents remain readable.
- R9: A first byte that arrives before the current frame is complete abandons the partial frame, and nothing of it is committed.
- R10: Frames that run past RAM address 63 continue at address 0, both when they are stored and when they are read through the window.
- R11: A release and a frame commit in the same cycle both take effect, so msgCount is unchanged and startAddr still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| resetMode | input | 1 | Controller reset mode (software request or bus-off) |
| wrValid | input | 1 | Frame byte valid from the protocol core |
| wrFirst | input | 1 | Byte is the descriptor that opens a frame |
| wrTx | input | 1 | Frame is self-transmitted (sampled with the first byte) |
| wrData | input | 8 | Frame byte |
| relCmd | input | 1 | Release the head frame |
| clrOvr | input | 1 | Clear the overrun flag |
| rbAddr | input | 4 | Receive window offset |
| rbData | output | 8 | Receive window data |
| rbFull | output | 1 | At least one frame is held |
| rxIrq | output | 1 | Receive interrupt request |
| msgCount | output | 7 | Number of committed frames |
| overrun | output | 1 | Data overrun flag |
| startAddr | output | 6 | RAM address of the head frame |

## Verification
The hardest situations to reach from the ports depend on where the pointers stand. A pointer rewind is only meaningful once the start address has moved away from 0. A wrapped frame needs the write position close to address 63. A dropped transmit needs the RAM almost full. The stimulus therefore first commits and releases two frames so that the start address reaches 18, and it writes a transmitted frame there. It then rewinds, and fills the RAM with four 13-byte frames that cross the end of the RAM. Overflowing frames, both received and transmitted, are then offered against the remaining 12 free bytes. A behavioural byte-array model is compared with every output on every clock, alongside directed checks at the fixed addresses this sequence produces.

// File: rtl/canrx_fifo_pkg.sv
package canrx_fifo_pkg;

  // frame length and offset widths (longest frame is 13 bytes)
  localparam int LW   = 5;
  localparam int OFFW = 4;

  typedef struct packed {
    logic wrEn;    // store wrData at write position + offset
    logic commit;  // received frame complete
    logic relGo;   // host release (reset mode already excluded)
    logic rewind;  // reset mode: flush and rewind to start
    logic setOvr;  // received frame rejected for lack of space
    logic clrOvr;  // host clears overrun
  } strobe_t;

  function automatic logic [LW-1:0] descLen(input logic ext, input logic [3:0] dlc);
    logic [3:0] capped;
    capped = (dlc > 4'd8) ? 4'd8 : dlc;
    return (ext ? LW'(5) : LW'(3)) + LW'(capped);
  endfunction

endpackage

// File: rtl/canrx_fifo_ctrl.sv
module canrx_fifo_ctrl
  import canrx_fifo_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            resetMode,
  input  logic            wrValid,
  input  logic            wrFirst,
  input  logic            wrTx,
  input  logic [7:0]      wrData,
  input  logic            relCmd,
  input  logic            clrOvr,
  input  logic [CW-1:0]   freeBytes,
  output strobe_t         stb,
  output logic [OFFW-1:0] wrOff,
  output logic [LW-1:0]   frmLen
);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_DROP} state_t;

  state_t        state;
  logic [LW-1:0] idx;
  logic [LW-1:0] lenQ;
  logic          txQ;
  logic [LW-1:0] newLen;
  logic          fits;
  logic          lastByte;

  assign newLen   = descLen(wrData[7], wrData[3:0]);
  assign fits     = CW'(newLen) <= freeBytes;
  assign lastByte = (idx == lenQ - LW'(1));
  assign frmLen   = lenQ;

  always_comb begin
    stb        = '0;
    wrOff      = idx[OFFW-1:0];
    stb.rewind = resetMode;
    stb.relGo  = relCmd && !resetMode;
    stb.clrOvr = clrOvr;
    if (!resetMode && wrValid) begin
      if (wrFirst) begin
        wrOff = '0;
        if (fits)       stb.wrEn   = 1'b1;
        else if (!wrTx) stb.setOvr = 1'b1;
      end else if (state == S_FILL) begin
        stb.wrEn = 1'b1;
        if (lastByte && !txQ) stb.commit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
      lenQ  <= '0;
      txQ   <= 1'b0;
    end else if (resetMode) begin
      state <= S_IDLE;
    end else if (wrValid) begin
      if (wrFirst) begin
        state <= fits ? S_FILL : S_DROP;
        idx   <= LW'(1);
        lenQ  <= newLen;
        txQ   <= wrTx;
      end else if (state == S_FILL) begin
        idx <= idx + LW'(1);
        if (lastByte) state <= S_IDLE;
      end
    end
  end

endmodule

// File: rtl/canrx_fifo_dp.sv
module canrx_fifo_dp
  import canrx_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [OFFW-1:0] wrOff,
  input  logic [LW-1:0]   frmLen,
  input  logic [7:0]      wrData,
  input  logic [OFFW-1:0] rdOff,
  output logic [7:0]      rdData,
  output logic [AW-1:0]   startAddr,
  output logic [CW-1:0]   freeBytes,
  output logic [CW-1:0]   msgCount,
  output logic            overrun,
  output logic            holding
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rdPtr;
  logic [AW-1:0] wrPtr;
  logic [CW-1:0] used;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cntNext;
  logic [LW-1:0] headLen;
  logic          relOk;
  logic          ovrQ;
  logic          holdQ;
  logic [7:0]    headDesc;

  assign headDesc  = mem[rdPtr];
  assign headLen   = descLen(headDesc[7], headDesc[3:0]);
  assign relOk     = stb.relGo && (cnt != '0);
  assign rdData    = mem[rdPtr + AW'(rdOff)];
  assign freeBytes = CW'(DEPTH) - used;
  assign startAddr = rdPtr;
  assign msgCount  = cnt;
  assign overrun   = ovrQ;
  assign holding   = holdQ;

  always_comb begin
    if (stb.rewind) cntNext = '0;
    else            cntNext = cnt + CW'(stb.commit) - CW'(relOk);
  end

  // frame RAM: no reset, contents survive pointer rewinds
  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrPtr + AW'(wrOff)] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      used  <= '0;
      cnt   <= '0;
      ovrQ  <= 1'b0;
      holdQ <= 1'b0;
    end else begin
      cnt   <= cntNext;
      holdQ <= (cntNext != '0);
      if (stb.rewind) begin
        wrPtr <= rdPtr;
        used  <= '0;
        ovrQ  <= 1'b0;
      end else begin
        if (relOk)      rdPtr <= rdPtr + AW'(headLen);
        if (stb.commit) wrPtr <= wrPtr + AW'(frmLen);
        used <= used + (stb.commit ? CW'(frmLen) : '0) - (relOk ? CW'(headLen) : '0);
        if (stb.setOvr)      ovrQ <= 1'b1;
        else if (stb.clrOvr) ovrQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/canrx_fifo.sv
module canrx_fifo
  import canrx_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          resetMode,
  input  logic          wrValid,
  input  logic          wrFirst,
  input  logic          wrTx,
  input  logic [7:0]    wrData,
  input  logic          relCmd,
  input  logic          clrOvr,
  input  logic [3:0]    rbAddr,
  output logic [7:0]    rbData,
  output logic          rbFull,
  output logic          rxIrq,
  output logic [CW-1:0] msgCount,
  output logic          overrun,
  output logic [AW-1:0] startAddr
);

  strobe_t         stb;
  logic [OFFW-1:0] wrOff;
  logic [LW-1:0]   frmLen;
  logic [CW-1:0]   freeBytes;
  logic            holding;

  canrx_fifo_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .resetMode(resetMode),
    .wrValid(wrValid), .wrFirst(wrFirst), .wrTx(wrTx), .wrData(wrData),
    .relCmd(relCmd), .clrOvr(clrOvr), .freeBytes(freeBytes),
    .stb(stb), .wrOff(wrOff), .frmLen(frmLen)
  );

  canrx_fifo_dp #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrOff(wrOff), .frmLen(frmLen),
    .wrData(wrData), .rdOff(rbAddr), .rdData(rbData), .startAddr(startAddr),
    .freeBytes(freeBytes), .msgCount(msgCount), .overrun(overrun),
    .holding(holding)
  );

  assign rbFull = holding;
  assign rxIrq  = holding;

endmodule

// File: rtl/canrx_fifo_chk.sv
module canrx_fifo_chk #(
  parameter int AW = 6,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rstN,
  input logic          resetMode,
  input logic          wrValid,
  input logic          relCmd,
  input logic          clrOvr,
  input logic          rbFull,
  input logic          rxIrq,
  input logic [CW-1:0] msgCount,
  input logic          overrun,
  input logic [AW-1:0] startAddr
);

  a_r3_status_tracks_count: assert property (@(posedge clk) disable iff (!rstN)
    rbFull == (msgCount != '0));

  a_r3_irq_tracks_count: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq == (msgCount != '0));

  a_r5_release_moves_start: assert property (@(posedge clk) disable iff (!rstN)
    (relCmd && !resetMode && msgCount != '0) |=> (startAddr != $past(startAddr)));

  a_r5_start_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(relCmd && !resetMode && msgCount != '0) |=> $stable(startAddr));

  a_r8_rewind_flushes: assert property (@(posedge clk) disable iff (!rstN)
    resetMode |=> (msgCount == '0 && !overrun));

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clrOvr && !resetMode) |=> overrun);

  a_r2_count_needs_byte: assert property (@(posedge clk) disable iff (!rstN)
    (msgCount > $past(msgCount)) |-> $past(wrValid && !resetMode));

endmodule

bind canrx_fifo canrx_fifo_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .resetMode(resetMode), .wrValid(wrValid),
  .relCmd(relCmd), .clrOvr(clrOvr), .rbFull(rbFull), .rxIrq(rxIrq),
  .msgCount(msgCount), .overrun(overrun), .startAddr(startAddr)
);

// File: tb/canrx_fifo_test.sv
`timescale 1ns/1ps
module canrx_fifo_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       resetMode = 1'b0, wrValid = 1'b0, wrFirst = 1'b0, wrTx = 1'b0;
  logic [7:0] wrData = '0;
  logic       relCmd = 1'b0, clrOvr = 1'b0;
  logic [3:0] rbAddr = '0;
  logic [7:0] rbData;
  logic       rbFull, rxIrq, overrun;
  logic [6:0] msgCount;
  logic [5:0] startAddr;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // behavioural reference
  int mem [64];
  int mrd = 0, mwr = 0, mused = 0, mcnt = 0, movr = 0;
  int mst = 0, midx = 0, mlen = 0, mtx = 0;

  always #4 clk = ~clk;

  canrx_fifo uut (
    .clk(clk), .rstN(rstN), .resetMode(resetMode), .wrValid(wrValid),
    .wrFirst(wrFirst), .wrTx(wrTx), .wrData(wrData), .relCmd(relCmd),
    .clrOvr(clrOvr), .rbAddr(rbAddr), .rbData(rbData), .rbFull(rbFull),
    .rxIrq(rxIrq), .msgCount(msgCount), .overrun(overrun), .startAddr(startAddr)
  );

  function automatic int flen(int d);
    int dl;
    dl = d & 15;
    if (dl > 8) dl = 8;
    return (((d & 128) != 0) ? 5 : 3) + dl;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    int hl, nl, relOk, commit, setO;
    if (resetMode) begin
      mwr = mrd; mused = 0; mcnt = 0; movr = 0; mst = 0;
      return;
    end
    hl = (mem[mrd] >= 0) ? flen(mem[mrd]) : 0;
    relOk = (relCmd && mcnt > 0) ? 1 : 0;
    commit = 0; setO = 0;
    if (wrValid) begin
      if (wrFirst) begin
        nl = flen(int'(wrData));
        if (nl <= 64 - mused) begin
          mem[mwr] = int'(wrData); mst = 1;
        end else begin
          mst = 2;
          if (!wrTx) setO = 1;
        end
        midx = 1; mlen = nl; mtx = int'(wrTx);
      end else if (mst == 1) begin
        mem[(mwr + midx) % 64] = int'(wrData);
        if (midx == mlen - 1) begin
          mst = 0;
          if (mtx == 0) commit = 1;
        end
        midx++;
      end
    end
    if (relOk != 0) mrd = (mrd + hl) % 64;
    if (commit != 0) mwr = (mwr + mlen) % 64;
    mused = mused + (commit * mlen) - (relOk * hl);
    mcnt = mcnt + commit - relOk;
    if (setO != 0) movr = 1;
    else if (clrOvr) movr = 0;
  endtask

  task automatic compareAll();
    int a;
    chk("R2 msgCount", int'(msgCount), mcnt);
    chk("R5 startAddr", int'(startAddr), mrd);
    chk("R6 overrun", int'(overrun), movr);
    chk("R3 rbFull", int'(rbFull), (mcnt != 0) ? 1 : 0);
    chk("R3 rxIrq", int'(rxIrq), (mcnt != 0) ? 1 : 0);
    a = (mrd + int'(rbAddr)) % 64;
    if (mem[a] >= 0) chk("R4 rbData", int'(rbData), mem[a]);
  endtask

  task automatic cyc();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    rbAddr = rbAddr + 4'd1;
  endtask

  task automatic quiet();
    wrValid = 0; wrFirst = 0; wrTx = 0; relCmd = 0; clrOvr = 0; resetMode = 0;
    cyc();
  endtask

  task automatic sendBytes(int desc, int tag, int tx, int n, int relLast);
    for (int k = 0; k < n; k++) begin
      wrValid = 1; wrFirst = (k == 0); wrTx = tx[0];
      wrData = (k == 0) ? 8'(desc) : 8'((tag << 4) | k);
      relCmd = (relLast != 0) && (k == n - 1);
      cyc();
    end
    wrValid = 0; wrFirst = 0; wrTx = 0; relCmd = 0;
  endtask

  task automatic sendFrame(int desc, int tag, int tx);
    sendBytes(desc, tag, tx, flen(desc), 0);
  endtask

  task automatic release1();
    relCmd = 1; cyc(); relCmd = 0;
  endtask

  task automatic peek(int off, int exp, string tag);
    rbAddr = 4'(off);
    #1;
    chk(tag, int'(rbData), exp);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = -1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 startAddr", int'(startAddr), 0);
    chk("R1 msgCount", int'(msgCount), 0);
    chk("R1 rbFull", int'(rbFull), 0);
    chk("R1 rxIrq", int'(rxIrq), 0);
    chk("R1 overrun", int'(overrun), 0);
    rstN = 1;
    quiet();

    // R2: standard 5-byte and extended 13-byte (dlc capped) frames
    sendFrame(8'h02, 1, 0);
    chk("R2 count after first frame", int'(msgCount), 1);
    peek(0, 8'h02, "R4 head descriptor");
    peek(4, 8'h14, "R4 head last byte");
    sendFrame(8'h8A, 2, 0);
    chk("R2 count after second frame", int'(msgCount), 2);

    // R5: releases and an ignored release
    release1();
    chk("R5 start after release", int'(startAddr), 5);
    release1();
    chk("R5 start after 13-byte release", int'(startAddr), 18);
    release1();
    chk("R5 empty release ignored", int'(startAddr), 18);

    // R7: transmitted frame visible but not counted
    sendFrame(8'h01, 3, 1);
    chk("R7 tx no count", int'(msgCount), 0);
    chk("R7 tx no irq", int'(rxIrq), 0);
    peek(0, 8'h01, "R7 tx frame readable");

    // R8: rewind keeps start, keeps RAM
    resetMode = 1; cyc(); resetMode = 0;
    chk("R8 start kept", int'(startAddr), 18);
    peek(1, 8'h31, "R8 stale data readable");

    // R10 / R6: four 13-byte frames wrap, fifth overflows
    for (int f = 4; f < 8; f++) sendFrame(8'h88, f, 0);
    chk("R10 four frames held", int'(msgCount), 4);
    sendFrame(8'h88, 9, 0);
    chk("R6 overrun set", int'(overrun), 1);
    chk("R6 frame discarded", int'(msgCount), 4);
    sendFrame(8'h88, 10, 1);
    chk("R7 tx overflow no overrun side effect", int'(msgCount), 4);
    quiet();
    chk("R6 overrun sticky", int'(overrun), 1);
    clrOvr = 1; cyc(); clrOvr = 0;
    chk("R6 overrun cleared", int'(overrun), 0);
    release1(); release1(); release1();
    chk("R10 wrapped start", int'(startAddr), 57);
    peek(10, 8'h7A, "R10 byte past address 63");
    peek(6, 8'h76, "R10 byte before wrap");

    // R11: release on the commit cycle
    sendBytes(8'h03, 11, 0, 6, 1);
    chk("R11 count unchanged", int'(msgCount), 1);
    chk("R11 start advanced", int'(startAddr), 6);

    // R9: abandoned partial frame
    sendBytes(8'h05, 12, 0, 3, 0);
    sendFrame(8'h00, 13, 0);
    chk("R9 only one commit", int'(msgCount), 2);

    // R8: partial frame cut by reset mode, later bytes ignored
    sendBytes(8'h02, 14, 0, 2, 0);
    resetMode = 1; relCmd = 1; cyc(); relCmd = 0; resetMode = 0;
    chk("R8 flushed", int'(msgCount), 0);
    for (int k = 0; k < 4; k++) begin
      wrValid = 1; wrFirst = 0; wrData = 8'hEE; cyc();
    end
    wrValid = 0;
    chk("R8 orphan bytes ignored", int'(msgCount), 0);

    // R6: reset mode clears overrun
    for (int f = 0; f < 5; f++) sendFrame(8'h88, f, 0);
    chk("R6 overrun again", int'(overrun), 1);
    resetMode = 1; cyc(); resetMode = 0;
    chk("R6 reset mode clears overrun", int'(overrun), 0);

    for (int i = 0; i < 40; i++) begin
      if (i % 7 == 0) sendFrame(8'h80 | (i % 12), i % 16, (i % 3 == 0) ? 1 : 0);
      else if (i % 5 == 0) release1();
      else quiet();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule